// File: doc/BRIEF.md
# USB IN Endpoint Transmit Controller

This block decides how a USB function endpoint answers an IN token and then runs the answer. When a token arrives for endpoint `n`, the block reads that endpoint's two-bit response mode and its transmit FIFO fill. From these it picks one of four actions: send the data packet, request a NAK handshake, request a STALL handshake, or stay silent. A data packet starts only when the FIFO holds enough bytes to avoid an underrun, or when it already holds the final byte of the packet.

During a data packet, FIFO bytes move from a valid/ready input stream to a valid/ready output stream. Back-pressure on the output (`tx_ready` low) passes straight to the input: `in_ready` follows `tx_ready` during the payload. An offered byte must stay stable until it is taken. After the byte flagged by `in_last`, the block appends the USB data CRC16 as two bytes. It then waits a programmable number of bit times for the host's ACK. If no ACK arrives in that time, it sets a timeout flag. Line coding, DATA0/DATA1 selection and the filling of the FIFO are handled elsewhere.

Top module: `usb_in_ep_tx`

## Requirements
- R1: The mode of endpoint `n` is `ep_mode[2n+1:2n]`, where 00 is normal, 01 is ignore, 10 is forced NAK and 11 is STALL. In normal mode with the FIFO ready, the payload bytes appear on `tx_data` in FIFO order. `tx_sop` is set on the first byte only.
- R2: In normal mode with the FIFO not ready, a token produces a one-cycle `hs_req` with `hs_stall`=0 (NAK) in the cycle after the token, and no packet is sent.
- R3: In ignore mode with the FIFO not ready, there is no `hs_req` and no `tx_valid`. In ignore mode with the FIFO ready, the packet is sent as in normal mode.
- R4: In forced-NAK mode, a token produces `hs_req` with `hs_stall`=0, even when the FIFO is ready.
- R5: In STALL mode, a token produces `hs_req` with `hs_stall`=1, and no packet is sent.
- R6: The FIFO of endpoint `n` is ready when `fifo_level[n]` ≥ 4 or `fifo_has_last[n]` is 1.
- R7: After the last payload byte, two CRC bytes follow, flagged by `tx_crc`. They carry the complement of the CRC16 (polynomial x^16+x^15+x^2+1, reflected, initial 0xFFFF), low byte first. `tx_eop` is set on the second CRC byte. A ready FIFO with a level of 0 sends the two CRC bytes only, both 0x00.
- R8: While `tx_valid`=1 and `tx_ready`=0, `tx_data` holds. During the payload, `in_ready` equals `tx_ready`.
- R9: An `rx_hs_valid` with `rx_hs_ack`=1 within `TMO_BITS*CLKS_PER_BIT` cycles after the last CRC byte produces a one-cycle `done` with `tmo_flag`=0. An ACK in the final cycle of the window still counts.
- R10: If no ACK arrives in that window, `tmo_flag` is set and `done` pulses at its last cycle. The next accepted token clears `tmo_flag`.
- R11: A token that arrives while a transaction is in progress is ignored.
- R12: `fifo_sel` carries the endpoint number of the token being served, for the whole packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | IN token strobe |
| tok_ep | input | EPW | Endpoint number of the token |
| ep_mode | input | 2*NUM_EP | Response mode per endpoint |
| fifo_level | input | NUM_EP*CW | Byte count of each transmit FIFO |
| fifo_has_last | input | NUM_EP | FIFO already holds the final packet byte |
| fifo_sel | output | EPW | Endpoint whose FIFO is being read |
| in_valid | input | 1 | FIFO byte valid |
| in_ready | output | 1 | FIFO byte taken |
| in_data | input | 8 | FIFO byte |
| in_last | input | 1 | Final payload byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts byte |
| tx_data | output | 8 | Transmit byte |
| tx_sop | output | 1 | First byte of packet |
| tx_eop | output | 1 | Final byte of packet |
| tx_crc | output | 1 | Byte is part of the CRC |
| hs_req | output | 1 | Send a handshake packet (one cycle) |
| hs_stall | output | 1 | Handshake is STALL (1) or NAK (0) |
| rx_hs_valid | input | 1 | Handshake received from host |
| rx_hs_ack | input | 1 | Received handshake is ACK |
| tmo_flag | output | 1 | Host handshake timed out |
| done | output | 1 | Data transaction finished (one cycle) |

## Verification
The bench uses four endpoints, 16-byte FIFOs and a start threshold of 4. It sets 2 clocks per bit and keeps 18 bit times for the timeout, so the full 36-cycle handshake window is walked edge by edge. This also lets the bench place an ACK in the very cycle the window expires. Packets of 0 to 18 bytes, with random stalls on both streams, cover the zero-length CRC-only case and fills just below, at and above the threshold.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_IGNORE = 2'b01,
    MODE_FNAK   = 2'b10,
    MODE_STALL  = 2'b11
  } ep_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE, ACT_NAK, ACT_STALL, ACT_DATA
  } resp_act_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_CRC_LO, ST_CRC_HI, ST_WAIT
  } tx_state_e;

  // Reflected CRC16 step over one byte (poly 0x8005, reflected 0xA001).
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/usb_in_resp_dec.sv
module usb_in_resp_dec
  import usb_in_ep_pkg::*;
#(
  parameter int CW     = 5,
  parameter int THRESH = 4
) (
  input  logic [1:0]    mode,
  input  logic [CW-1:0] level,
  input  logic          has_last,
  output resp_act_e     act,
  output logic          zero_len
);
  logic ready;

  assign ready    = (32'(level) >= THRESH) || has_last;
  assign zero_len = has_last && (level == '0);

  always_comb begin
    unique case (ep_mode_e'(mode))
      MODE_NORMAL: act = ready ? ACT_DATA : ACT_NAK;
      MODE_IGNORE: act = ready ? ACT_DATA : ACT_NONE;
      MODE_FNAK:   act = ACT_NAK;
      default:     act = ACT_STALL;
    endcase
  end
endmodule

// File: rtl/usb_crc16_acc.sv
module usb_crc16_acc
  import usb_in_ep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= 16'hFFFF;
    else if (clr) crc <= 16'hFFFF;
    else if (en)  crc <= crc16_byte(crc, data);
  end
endmodule

// File: rtl/usb_hs_timer.sv
module usb_hs_timer #(
  parameter int LIMIT = 36,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign expire = run && (32'(cnt) == LIMIT - 1);
endmodule

// File: rtl/usb_in_ep_tx.sv
module usb_in_ep_tx
  import usb_in_ep_pkg::*;
#(
  parameter int NUM_EP       = 4,
  parameter int FIFO_DEPTH   = 16,
  parameter int THRESH       = 4,
  parameter int TMO_BITS     = 18,
  parameter int CLKS_PER_BIT = 4,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int CW  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tok_valid,
  input  logic [EPW-1:0]       tok_ep,
  input  logic [2*NUM_EP-1:0]  ep_mode,
  input  logic [NUM_EP*CW-1:0] fifo_level,
  input  logic [NUM_EP-1:0]    fifo_has_last,
  output logic [EPW-1:0]       fifo_sel,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  input  logic                 in_last,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  output logic                 tx_sop,
  output logic                 tx_eop,
  output logic                 tx_crc,
  output logic                 hs_req,
  output logic                 hs_stall,
  input  logic                 rx_hs_valid,
  input  logic                 rx_hs_ack,
  output logic                 tmo_flag,
  output logic                 done
);
  localparam int TMO_CYC = TMO_BITS * CLKS_PER_BIT;

  tx_state_e      st;
  logic [EPW-1:0] ep_q;
  logic           sop_pend;
  logic           busy;
  logic [1:0]     mode_a  [NUM_EP];
  logic [CW-1:0]  level_a [NUM_EP];
  resp_act_e      act;
  logic           zero_len;
  logic           tok_take;
  logic           beat;
  logic [15:0]    crc;
  logic           expire;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    assign mode_a[g]  = ep_mode[2*g +: 2];
    assign level_a[g] = fifo_level[CW*g +: CW];
  end

  usb_in_resp_dec #(.CW(CW), .THRESH(THRESH)) u_dec (
    .mode(mode_a[tok_ep]), .level(level_a[tok_ep]),
    .has_last(fifo_has_last[tok_ep]), .act(act), .zero_len(zero_len)
  );

  assign busy     = (st != ST_IDLE);
  assign tok_take = tok_valid && !busy;
  assign beat     = (st == ST_DATA) && in_valid && tx_ready;

  usb_crc16_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(tok_take), .en(beat), .data(in_data), .crc(crc)
  );

  usb_hs_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(st == ST_WAIT), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ep_q     <= '0;
      sop_pend <= 1'b0;
      hs_req   <= 1'b0;
      hs_stall <= 1'b0;
      tmo_flag <= 1'b0;
      done     <= 1'b0;
    end else begin
      hs_req <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        ST_IDLE: if (tok_valid) begin
          ep_q     <= tok_ep;
          tmo_flag <= 1'b0;
          unique case (act)
            ACT_NAK:   begin hs_req <= 1'b1; hs_stall <= 1'b0; end
            ACT_STALL: begin hs_req <= 1'b1; hs_stall <= 1'b1; end
            ACT_DATA:  begin
              sop_pend <= 1'b1;
              st       <= zero_len ? ST_CRC_LO : ST_DATA;
            end
            default: ;
          endcase
        end
        ST_DATA: if (beat) begin
          sop_pend <= 1'b0;
          if (in_last) st <= ST_CRC_LO;
        end
        ST_CRC_LO: if (tx_ready) begin
          sop_pend <= 1'b0;
          st       <= ST_CRC_HI;
        end
        ST_CRC_HI: if (tx_ready) st <= ST_WAIT;
        ST_WAIT: begin
          if (rx_hs_valid && rx_hs_ack) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else if (expire) begin
            tmo_flag <= 1'b1;
            done     <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign fifo_sel = ep_q;
  assign tx_crc   = (st == ST_CRC_LO) || (st == ST_CRC_HI);
  assign tx_valid = ((st == ST_DATA) && in_valid) || tx_crc;
  assign in_ready = (st == ST_DATA) && tx_ready;
  assign tx_sop   = tx_valid && sop_pend;
  assign tx_eop   = (st == ST_CRC_HI);

  always_comb begin
    unique case (st)
      ST_CRC_LO: tx_data = ~crc[7:0];
      ST_CRC_HI: tx_data = ~crc[15:8];
      default:   tx_data = in_data;
    endcase
  end
endmodule

// File: rtl/usb_in_ep_tx_chk.sv
module usb_in_ep_tx_chk #(
  parameter int NUM_EP = 4,
  parameter int EPW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               tok_valid,
  input logic [EPW-1:0]     tok_ep,
  input logic [2*NUM_EP-1:0] ep_mode,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [7:0]         tx_data,
  input logic               tx_eop,
  input logic               tx_crc,
  input logic               hs_req,
  input logic               hs_stall,
  input logic               tmo_flag,
  input logic               done
);
  p_stall_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tok_valid && ep_mode[2*tok_ep +: 2] == 2'b11) |=> (hs_req && hs_stall));

  p_fnak_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tok_valid && ep_mode[2*tok_ep +: 2] == 2'b10) |=> (hs_req && !hs_stall));

  p_busy_tok_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tok_valid) |=> !hs_req);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_eop && tx_crc) |=> (tx_valid && $stable(tx_data)));

  p_eop_on_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eop |-> (tx_crc && tx_valid));

  p_tmo_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> done);

  p_hs_no_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_req |-> !tx_valid);
endmodule

bind usb_in_ep_tx usb_in_ep_tx_chk #(.NUM_EP(NUM_EP), .EPW(EPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tok_valid(tok_valid), .tok_ep(tok_ep),
  .ep_mode(ep_mode), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_eop(tx_eop), .tx_crc(tx_crc), .hs_req(hs_req), .hs_stall(hs_stall),
  .tmo_flag(tmo_flag), .done(done)
);

// File: tb/usb_in_ep_tx_tb.sv
`timescale 1ns/1ps
module usb_in_ep_tx_tb;
  localparam int NUM_EP = 4;
  localparam int CW     = 5;
  localparam int CPB    = 2;
  localparam int TBITS  = 18;
  localparam int WIN    = TBITS * CPB;

  logic clk = 0, rst_n = 0;
  logic tok_valid = 0;
  logic [1:0] tok_ep = 0;
  logic [2*NUM_EP-1:0] ep_mode = 0;
  logic [NUM_EP*CW-1:0] fifo_level = 0;
  logic [NUM_EP-1:0] fifo_has_last = 0;
  logic [1:0] fifo_sel;
  logic in_valid = 0, in_ready, in_last = 0;
  logic [7:0] in_data = 0;
  logic tx_valid, tx_ready = 1, tx_sop, tx_eop, tx_crc;
  logic [7:0] tx_data;
  logic hs_req, hs_stall, rx_hs_valid = 0, rx_hs_ack = 0, tmo_flag, done;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  usb_in_ep_tx #(.NUM_EP(NUM_EP), .FIFO_DEPTH(16), .THRESH(4), .TMO_BITS(TBITS),
                 .CLKS_PER_BIT(CPB)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // 0 none, 1 NAK, 2 STALL, 3 data
  function automatic int exp_kind(input int mode, input int level, input bit last);
    bit rdy = (level >= 4) || last;
    case (mode)
      0: return rdy ? 3 : 1;
      1: return rdy ? 3 : 0;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] d);
    for (int b = 0; b < 8; b++) begin
      logic fb = c[0] ^ d[b];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  // ack_at: 0 = never (timeout), else cycle after the last CRC byte; intr: busy-token cycle
  task automatic run_txn(input int ep, input int mode, input int level, input bit last,
                         input int n, input int ack_at, input int intr, input string tag);
    logic [7:0] pkt[20];
    logic [7:0] eb[22];
    logic [15:0] c = 16'hFFFF;
    int kind = exp_kind(mode, level, last);
    for (int i = 0; i < 20; i++) pkt[i] = 8'($urandom);
    for (int i = 0; i < n; i++) begin eb[i] = pkt[i]; c = crc_bits(c, pkt[i]); end
    eb[n] = ~c[7:0]; eb[n+1] = ~c[15:8];
    @(negedge clk);
    ep_mode[2*ep +: 2] = 2'(mode);
    fifo_level[CW*ep +: CW] = CW'(level);
    fifo_has_last[ep] = last;
    tok_valid = 1; tok_ep = 2'(ep);
    @(posedge clk); #1;
    chk(hs_req == (kind == 1 || kind == 2), tag, "hs_req", hs_req, kind == 1 || kind == 2);
    if (kind == 2) chk(hs_stall == 1, "R5", "hs_stall", hs_stall, 1);
    if (kind == 1) chk(hs_stall == 0, tag, "hs_stall nak", hs_stall, 0);
    if (kind != 3) begin
      bit quiet = 1;
      @(negedge clk); tok_valid = 0;
      for (int i = 0; i < 3; i++) begin
        @(posedge clk); #1;
        if (tx_valid || hs_req) quiet = 0;
      end
      chk(quiet, tag, "no packet after handshake/ignore", !quiet, 0);
    end else begin
      int idx = 0, got = 0, bad = 0;
      bit vld = 0, fin = 0;
      for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
        @(negedge clk); tok_valid = 0;
        if (!vld && idx < n && ($urandom % 4 != 0)) vld = 1;
        in_valid = vld; in_data = pkt[idx]; in_last = (idx == n - 1);
        tx_ready = ($urandom % 4 != 0);
        #1;
        if (tx_valid && tx_ready) begin
          if (tx_data !== eb[got]) begin
            bad++; $display("FAIL %s R7 byte %0d: actual %0h expected %0h", tag, got, tx_data, eb[got]);
          end
          if (tx_sop !== (got == 0) || tx_eop !== (got == n + 1) || tx_crc !== (got >= n)) begin
            bad++; $display("FAIL R1 framing byte %0d: actual %b%b%b expected %b%b%b", got,
                            tx_sop, tx_eop, tx_crc, got == 0, got == n + 1, got >= n);
          end
          if (fifo_sel !== 2'(ep)) begin
            bad++; $display("FAIL R12 fifo_sel: actual %0d expected %0d", fifo_sel, ep);
          end
          got++;
          if (tx_eop) fin = 1;
        end
        if (!fin && tx_valid && !tx_crc && in_ready !== tx_ready) begin
          bad++; $display("FAIL R8 in_ready: actual %b expected %b", in_ready, tx_ready);
        end
        if (in_valid && in_ready) begin idx++; vld = 0; end
        @(posedge clk);
      end
      checks++;
      if (bad != 0 || got != n + 2) begin
        fails++;
        $display("FAIL %s packet: actual %0d bytes/%0d errors expected %0d bytes/0", tag, got, bad, n + 2);
      end
      @(negedge clk); in_valid = 0; tx_ready = 1;
      begin
        int last_i = (ack_at == 0) ? WIN : ack_at;
        int early = 0;
        // the negedge above already lies in window cycle 1
        for (int i = 1; i <= last_i; i++) begin
          if (i > 1) @(negedge clk);
          rx_hs_valid = (ack_at != 0) && (i == ack_at); rx_hs_ack = 1;
          tok_valid = (i == intr); tok_ep = 2'(ep ^ 1);
          ep_mode[2*(ep^1) +: 2] = 2'b11;
          @(posedge clk); #1;
          if (i == intr) chk(!hs_req, "R11", "busy token answered", hs_req, 0);
          if (i < last_i && done) early++;
        end
        chk(early == 0, ack_at ? "R9" : "R10", "early done", early, 0);
        chk(done == 1, ack_at ? "R9" : "R10", "done", done, 1);
        chk(tmo_flag == (ack_at == 0), ack_at ? "R9" : "R10", "tmo_flag", tmo_flag, ack_at == 0);
        @(negedge clk); rx_hs_valid = 0; tok_valid = 0;
      end
    end
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!hs_req && !tx_valid && !done && !tmo_flag && !in_ready, "R1", "reset outputs",
        {hs_req, tx_valid, done, tmo_flag, in_ready}, 0);
    @(negedge clk); rst_n = 1;
    run_txn(0, 0, 5, 0, 6, 3, 0, "R1");       // normal, above threshold, ACK early
    run_txn(1, 0, 3, 0, 3, 0, 0, "R2");       // normal, below threshold -> NAK
    run_txn(1, 0, 3, 1, 3, 1, 0, "R6");       // below threshold but last present -> data
    run_txn(2, 1, 0, 0, 0, 0, 0, "R3");       // ignore, empty -> silent
    run_txn(2, 1, 4, 0, 4, 2, 0, "R3");       // ignore, exactly threshold -> data
    run_txn(3, 2, 16, 1, 16, 0, 0, "R4");     // forced NAK with full FIFO
    run_txn(3, 3, 16, 1, 16, 0, 0, "R5");     // STALL
    run_txn(0, 0, 0, 1, 0, 4, 0, "R7");       // zero length: CRC only
    run_txn(1, 0, 8, 1, 8, 0, 5, "R10");      // timeout, busy token ignored
    run_txn(1, 0, 2, 0, 2, 0, 0, "R2");       // NAK token clears tmo_flag
    chk(!tmo_flag, "R10", "tmo_flag cleared", tmo_flag, 0);
    run_txn(2, 0, 16, 1, 16, WIN, 0, "R9");   // ACK in final window cycle
    for (int t = 0; t < 40; t++) begin
      int ep = $urandom % 4, md = $urandom % 4, lv = $urandom % 17;
      bit ls = ($urandom % 2);
      int n = ls ? lv : lv + ($urandom % 3);
      int ak = $urandom % (WIN + 1);
      run_txn(ep, md, lv, ls, n, ak, 0, "R1");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule